// File: doc/BRIEF.md
# Load-Store Unit with Single-Cycle Access Stall

This block sits between a processor core and a synchronous data memory that writes under a per-byte enable mask. The core presents a request, a write enable, an address, an access-size code and store data. The unit passes the request, write enable and address straight through to the memory. For stores it builds the byte-enable mask from the size and the low address bits, and it copies the store data across the byte lanes. For loads it takes the addressed byte or halfword out of the memory's read word and widens it with either sign or zero extension.

The memory returns read data one clock after it sees a request. To cover that latency the unit holds the core with a stall for exactly one cycle at the start of every access. A new request raises the stall in the same cycle. In the next cycle the stall is low and the load result is valid. The core may withdraw or replace its request only in a cycle with no stall. When the core keeps its request high, the stall pattern repeats every two cycles.

Top module: `ldst_unit`

## Requirements
- R1: Outside reset, `memReq` always equals `coreReq` and `memWe` always equals `coreWe`.
- R2: While `coreReq` is high, `memAddr` equals `coreAddr`.
- R3: A rising edge of `coreReq` gives a rising edge of `coreStall` in the same cycle. `coreStall` is high only while `coreReq` is high, and it never stays high for two cycles in a row.
- R4: While `coreReq` is held high, no two consecutive cycles are both stall-free. The core drops `coreReq` only after a cycle in which `coreStall` was low.
- R5: While `rst` is high, `coreStall` is low and the internal stall register is cleared by the next clock edge. A request that is already high when reset ends stalls in the first cycle after reset.
- R6: `coreSize[1:0]` selects the width: 00 is byte, 01 is halfword, and 10 or 11 is word. On a store request, `memBe` is 4'b0001 shifted left by `coreAddr[1:0]` for a byte, 4'b0011 for a halfword when `coreAddr[1]` is 0 and 4'b1100 when it is 1, and 4'b1111 for a word. When there is no store request, `memBe` is 4'b0000.
- R7: On a store, `memWdata` holds four copies of `coreWdata[7:0]` for a byte, two copies of `coreWdata[15:0]` for a halfword, and `coreWdata` unchanged for a word.
- R8: Byte loads take the byte at lane `coreAddr[1:0]` of `memRdata` (lane k is bits 8k+7..8k). Code 3'b000 sign-extends the byte and code 3'b100 zero-extends it.
- R9: Halfword loads take bits 31..16 of `memRdata` when `coreAddr[1]` is 1 and bits 15..0 otherwise; `coreAddr[0]` is ignored. Code 3'b001 sign-extends the halfword and code 3'b101 zero-extends it.
- R10: Word loads (code 3'b010) return `memRdata` unchanged in the stall-free cycle. When no load is requested, `coreRdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coreReq | input | 1 | Core access request |
| coreWe | input | 1 | Core write enable (1 = store) |
| coreSize | input | 3 | Access size code; bit 2 selects zero extension |
| coreAddr | input | ADDR_W | Byte address |
| coreWdata | input | 32 | Store data, right-aligned |
| coreRdata | output | 32 | Extended load result |
| coreStall | output | 1 | Stall to the core |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write enable |
| memBe | output | 4 | Memory byte enables |
| memAddr | output | ADDR_W | Memory byte address |
| memWdata | output | 32 | Lane-replicated store data |
| memRdata | input | 32 | Memory read word, one cycle after the request |

## Verification
All pass-through outputs, the stall and the byte-lane outputs are combinational. The bench therefore checks them in the same cycle its inputs change, sampling on the falling edge after driving just past the rising edge. Load results depend on the memory's registered read word, so they are checked one cycle after the request appears, in the stall-free cycle. The bench's memory model captures the word on the rising edge that ends the stall cycle. A behavioural stall model advances on every rising edge, and a shadow memory updated from the expected masks supplies the expected load values. Store mistakes therefore also show up in later loads.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    WID_BYTE = 2'b00,
    WID_HALF = 2'b01,
    WID_WORD = 2'b10,
    WID_WRD2 = 2'b11
  } accWidth_e;

  typedef struct packed {
    logic stall;
    logic storeEn;
    logic loadEn;
  } ctrlStrb_t;
endpackage

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      coreReq,
  input  logic      coreWe,
  output ctrlStrb_t strb,
  output logic      stallHeld
);
  logic stallNow;

  assign stallNow = coreReq & ~stallHeld & ~rst;

  always_ff @(posedge clk) begin
    if (rst) stallHeld <= 1'b0;
    else     stallHeld <= stallNow;
  end

  always_comb begin
    strb.stall   = stallNow;
    strb.storeEn = coreReq & coreWe & ~rst;
    strb.loadEn  = coreReq & ~coreWe & ~rst;
  end
endmodule

// File: rtl/ldst_datapath.sv
module ldst_datapath
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  ctrlStrb_t           strb,
  input  logic [2:0]          coreSize,
  input  logic [ADDR_W-1:0]   coreAddr,
  input  logic [DATA_W-1:0]   coreWdata,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [LANES-1:0]    memBe,
  output logic [DATA_W-1:0]   memWdata,
  output logic [DATA_W-1:0]   coreRdata
);
  accWidth_e           width;
  logic [OFF_W-1:0]    offset;
  logic                zeroExt;
  logic [7:0]          pickByte;
  logic [15:0]         pickHalf;

  assign width   = accWidth_e'(coreSize[1:0]);
  assign offset  = coreAddr[OFF_W-1:0];
  assign zeroExt = coreSize[2];

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic laneHit;
    always_comb begin
      case (width)
        WID_BYTE: laneHit = (offset == OFF_W'(lane));
        WID_HALF: laneHit = (offset[OFF_W-1] == lane[OFF_W-1]);
        default:  laneHit = 1'b1;
      endcase
    end
    assign memBe[lane] = strb.storeEn & laneHit;

    always_comb begin
      case (width)
        WID_BYTE: memWdata[8*lane +: 8] = coreWdata[7:0];
        WID_HALF: memWdata[8*lane +: 8] = coreWdata[8*(lane % 2) +: 8];
        default:  memWdata[8*lane +: 8] = coreWdata[8*lane +: 8];
      endcase
    end
  end

  assign pickByte = memRdata[8*offset +: 8];
  assign pickHalf = memRdata[16*offset[OFF_W-1] +: 16];

  always_comb begin
    coreRdata = '0;
    if (strb.loadEn) begin
      case (width)
        WID_BYTE: coreRdata = {{(DATA_W-8){pickByte[7] & ~zeroExt}}, pickByte};
        WID_HALF: coreRdata = {{(DATA_W-16){pickHalf[15] & ~zeroExt}}, pickHalf};
        default:  coreRdata = memRdata;
      endcase
    end
  end
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              coreReq,
  input  logic              coreWe,
  input  logic [2:0]        coreSize,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [31:0]       coreWdata,
  output logic [31:0]       coreRdata,
  output logic              coreStall,
  output logic              memReq,
  output logic              memWe,
  output logic [3:0]        memBe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata
);
  ctrlStrb_t strb;
  logic      stallHeld;

  ldst_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .coreReq   (coreReq),
    .coreWe    (coreWe),
    .strb      (strb),
    .stallHeld (stallHeld)
  );

  ldst_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .strb      (strb),
    .coreSize  (coreSize),
    .coreAddr  (coreAddr),
    .coreWdata (coreWdata),
    .memRdata  (memRdata),
    .memBe     (memBe),
    .memWdata  (memWdata),
    .coreRdata (coreRdata)
  );

  assign coreStall = strb.stall;
  assign memReq    = coreReq;
  assign memWe     = coreWe;
  assign memAddr   = coreAddr;
endmodule

// File: rtl/ldst_unit_chk.sv
module ldst_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              coreReq,
  input logic              coreWe,
  input logic [2:0]        coreSize,
  input logic [ADDR_W-1:0] coreAddr,
  input logic              coreStall,
  input logic              memReq,
  input logic              memWe,
  input logic [3:0]        memBe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              stallHeld
);
  // R1
  req_follow_chk: assert property (@(posedge clk) disable iff (rst) memReq == coreReq);
  // R1
  we_follow_chk: assert property (@(posedge clk) disable iff (rst) memWe == coreWe);
  // R2
  addr_pass_chk: assert property (@(posedge clk) disable iff (rst) coreReq |-> memAddr == coreAddr);
  // R3
  stall_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(coreReq) |-> $rose(coreStall));
  // R3
  stall_needs_req_chk: assert property (@(posedge clk) disable iff (rst) coreStall |-> coreReq);
  // R3
  stall_single_chk: assert property (@(posedge clk) disable iff (rst) coreStall |=> !coreStall);
  // R4
  stall_cadence_chk: assert property (@(posedge clk) disable iff (rst)
    coreReq |-> (coreStall || $past(coreStall)));
  // R4
  drop_when_free_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(coreReq) |-> !$past(coreStall));
  // R5
  rst_clear_chk: assert property (@(posedge clk) rst |=> !stallHeld);
  // R5
  rst_no_stall_chk: assert property (@(posedge clk) rst |-> !coreStall);
  // R6
  be_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (coreReq && coreWe && coreSize[1:0] == 2'b00) |-> $countones(memBe) == 1);
  // R6
  be_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(coreReq && coreWe) |-> memBe == 4'b0000);
endmodule

bind ldst_unit ldst_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .coreReq   (coreReq),
  .coreWe    (coreWe),
  .coreSize  (coreSize),
  .coreAddr  (coreAddr),
  .coreStall (coreStall),
  .memReq    (memReq),
  .memWe     (memWe),
  .memBe     (memBe),
  .memAddr   (memAddr),
  .stallHeld (stallHeld)
);

// File: tb/tb_ldst_unit.sv
`timescale 1ns/100ps
module tb_ldst_unit;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          coreReq = 1'b0;
  logic          coreWe = 1'b0;
  logic [2:0]    coreSize = 3'd2;
  logic [AW-1:0] coreAddr = '0;
  logic [31:0]   coreWdata = '0;
  logic [31:0]   coreRdata;
  logic          coreStall;
  logic          memReq;
  logic          memWe;
  logic [3:0]    memBe;
  logic [AW-1:0] memAddr;
  logic [31:0]   memWdata;
  logic [31:0]   memRdata = '0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] mem    [16];
  logic [31:0] shadow [16];
  bit refHeld = 0;
  int freeRun = 0;

  always #2.5 clk = ~clk;

  ldst_unit #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .coreReq(coreReq), .coreWe(coreWe), .coreSize(coreSize),
    .coreAddr(coreAddr), .coreWdata(coreWdata), .coreRdata(coreRdata), .coreStall(coreStall),
    .memReq(memReq), .memWe(memWe), .memBe(memBe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  function automatic logic [3:0] expBe(logic [2:0] sz, logic [1:0] off);
    if (sz[1:0] == 2'b00) begin
      case (off)
        2'd0: return 4'b0001;
        2'd1: return 4'b0010;
        2'd2: return 4'b0100;
        default: return 4'b1000;
      endcase
    end
    if (sz[1:0] == 2'b01) return off[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] expWd(logic [2:0] sz, logic [31:0] d);
    if (sz[1:0] == 2'b00) return {4{d[7:0]}};
    if (sz[1:0] == 2'b01) return {2{d[15:0]}};
    return d;
  endfunction

  function automatic logic [31:0] expLoad(logic [2:0] sz, logic [1:0] off, logic [31:0] w);
    logic [31:0] v;
    int bits;
    if (sz[1:0] == 2'b00) begin v = (w >> (off * 8)) & 32'hFF; bits = 8; end
    else if (sz[1:0] == 2'b01) begin v = (w >> (off[1] ? 16 : 0)) & 32'hFFFF; bits = 16; end
    else return w;
    if (!sz[2] && v[bits-1]) v = v | (32'hFFFF_FFFF << bits);
    return v;
  endfunction

  function automatic logic [31:0] mergeBytes(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = nw[8*k +: 8];
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // memory environment and reference models advance on the rising edge
  always @(posedge clk) begin
    if (!rst && memReq) begin
      if (memWe) mem[memAddr[5:2]] <= mergeBytes(mem[memAddr[5:2]], memWdata, memBe);
      else       memRdata <= mem[memAddr[5:2]];
    end
    if (!rst && coreReq && coreWe)
      shadow[coreAddr[5:2]] <= mergeBytes(shadow[coreAddr[5:2]], expWd(coreSize, coreWdata),
                                          expBe(coreSize, coreAddr[1:0]));
    refHeld <= rst ? 1'b0 : (coreReq && !refHeld);
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      check(coreStall == 1'b0, "R5", {31'd0, coreStall}, 32'd0);
    end else begin
      bit expStall;
      string ldTag;
      expStall = coreReq && !refHeld;
      check(memReq == coreReq, "R1", {31'd0, memReq}, {31'd0, coreReq});
      check(memWe == coreWe, "R1", {31'd0, memWe}, {31'd0, coreWe});
      if (coreReq) check(memAddr == coreAddr, "R2", memAddr, coreAddr);
      check(coreStall == expStall, "R3", {31'd0, coreStall}, {31'd0, expStall});
      if (coreReq && !coreStall) freeRun++; else freeRun = 0;
      check(freeRun < 2, "R4", freeRun, 1);
      check(memBe == ((coreReq && coreWe) ? expBe(coreSize, coreAddr[1:0]) : 4'b0000), "R6",
            {28'd0, memBe}, {28'd0, (coreReq && coreWe) ? expBe(coreSize, coreAddr[1:0]) : 4'b0000});
      if (coreReq && coreWe)
        check(memWdata == expWd(coreSize, coreWdata), "R7", memWdata, expWd(coreSize, coreWdata));
      if (coreReq && !coreWe && !coreStall) begin
        ldTag = (coreSize[1:0] == 2'b00) ? "R8" : (coreSize[1:0] == 2'b01) ? "R9" : "R10";
        check(coreRdata == expLoad(coreSize, coreAddr[1:0], shadow[coreAddr[5:2]]), ldTag,
              coreRdata, expLoad(coreSize, coreAddr[1:0], shadow[coreAddr[5:2]]));
      end
      if (!coreReq) check(coreRdata == 32'd0, "R10", coreRdata, 32'd0);
    end
  end

  task automatic access(bit we, logic [2:0] sz, logic [31:0] a, logic [31:0] d);
    coreReq = 1'b1; coreWe = we; coreSize = sz; coreAddr = a; coreWdata = d;
    @(posedge clk); @(posedge clk); #1;
  endtask

  task automatic idle();
    coreReq = 1'b0; coreWe = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'h8F7E_6D5C + i * 32'h1111_1111;
      shadow[i] = mem[i];
    end
    // R5: request already high during reset
    coreReq = 1'b1; coreWe = 1'b0; coreSize = 3'd2; coreAddr = 32'h0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    idle();
    // R6 R7: byte stores at every lane, back-to-back (R4)
    for (int off = 0; off < 4; off++)
      access(1'b1, 3'd0, 32'h10 + off, 32'h5A3C_1E80 + off * 32'h0101_0137);
    idle();
    access(1'b1, 3'd1, 32'h20, 32'h1234_F00D);
    access(1'b1, 3'd1, 32'h22, 32'hABCD_8421);
    idle();
    access(1'b1, 3'd2, 32'h30, 32'h9A3B_7C41);
    access(1'b1, 3'd0, 32'h3E, 32'h0000_0077);
    idle();
    // R8: byte loads signed and unsigned at every lane
    for (int off = 0; off < 4; off++) begin
      access(1'b0, 3'd0, 32'h10 + off, 32'h0);
      access(1'b0, 3'd4, 32'h10 + off, 32'h0);
      access(1'b0, 3'd0, 32'h4 + off, 32'h0);
      idle();
    end
    // R9: halfword loads, including odd addresses
    foreach (shadow[w]) begin
      if (w < 3) begin
        access(1'b0, 3'd1, 32'h20 + 4*w, 32'h0);
        access(1'b0, 3'd5, 32'h22 + 4*w, 32'h0);
        access(1'b0, 3'd1, 32'h23 + 4*w, 32'h0);
        access(1'b0, 3'd5, 32'h21 + 4*w, 32'h0);
        idle();
      end
    end
    // R10: word loads
    access(1'b0, 3'd2, 32'h30, 32'h0);
    access(1'b0, 3'd2, 32'h3C, 32'h0);
    access(1'b0, 3'd2, 32'h8, 32'h0);
    idle();
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R4 act=%h exp=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule